// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock line level for an I2C master, counted out from the system clock. A 16-bit timing word sets the two halves of the SCL period on their own: the upper byte gives the high-phase count and the lower byte gives the low-phase count. Each phase lasts one cycle more than its count. Counts below a safe floor are raised to that floor, and nothing reports that this happened.

The master state machine drives an enable. While the enable is low, SCL rests high. When the enable rises, the generator starts with a low phase and then alternates between low and high. Alongside the SCL level it gives a one-cycle pulse on every rising and falling SCL edge. It also gives a bit-period strobe each time a low phase completes, which marks one full period. Each phase takes its length from the timing word as it stands at the moment the phase begins. This lets software rewrite the word while the clock runs without distorting the phase in progress.

The timing word and enable are plain control pins and all outputs are plain status levels or pulses. The block carries no data stream, so it has no valid/ready handshake.

Top module: `i2c_scl_pacer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, scl_o is 1 and scl_rise_o, scl_fall_o and bit_done_o are 0.
- R2: While en_i is 0, scl_o is 1 from the next cycle on, and scl_fall_o and bit_done_o stay 0.
- R3: After en_i rises from 0, the next cycle shows scl_o = 0 with scl_fall_o = 1, so a run always opens with a low phase.
- R4: A low phase lasts (timing_i[7:0] + 1) system clock cycles.
- R5: A high phase lasts (timing_i[15:8] + 1) system clock cycles.
- R6: A low field (timing_i[7:0]) below 4 acts as 4, so a low phase is never shorter than 5 cycles.
- R7: A high field (timing_i[15:8]) below 2 acts as 2, so a high phase is never shorter than 3 cycles.
- R8: scl_rise_o and scl_fall_o are each 1 for exactly the first cycle of the new SCL level, and never both at once.
- R9: bit_done_o is 1 for one cycle, together with scl_rise_o, each time a low phase runs to completion.
- R10: The timing word is captured when a phase begins. A change to it during a phase does not alter that phase and applies from the next phase.
- R11: Dropping en_i during a low phase returns scl_o to 1 in the next cycle with scl_rise_o = 1 and bit_done_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable from the master state machine |
| timing_i | input | 16 | [15:8] high-phase count, [7:0] low-phase count |
| scl_o | output | 1 | SCL drive level (1 = released high) |
| scl_rise_o | output | 1 | One-cycle pulse on the first high cycle of SCL |
| scl_fall_o | output | 1 | One-cycle pulse on the first low cycle of SCL |
| bit_done_o | output | 1 | One-cycle strobe when a low phase completes |

## Verification
The bound checker checks the following on every cycle:
- SCL rests high and stays quiet while the block is disabled.
- Every edge pulse matches a real change of level, and the two edge pulses never coincide.
- The bit strobe always comes together with a rising edge.
- No completed low phase is shorter than the clamped floor.
- A disable during a low phase brings SCL straight back high.

Only the bench scenarios can show the exact phase lengths for chosen field values and the clamping of illegal small counts. They also show that a word rewritten mid-phase leaves the running phase alone and shapes only the phases that follow.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int unsigned FIELD_W_DEF = 8;
  localparam int unsigned HI_MIN_DEF  = 2;
  localparam int unsigned LO_MIN_DEF  = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/i2c_scl_floor.sv
// Raises a phase count to a minimum value.
module i2c_scl_floor #(
  parameter int unsigned W   = 8,
  parameter int unsigned MIN = 2
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] eff_o
);
  localparam logic [W-1:0] FLOOR = W'(MIN);

  always_comb begin
    eff_o = (raw_i < FLOOR) ? FLOOR : raw_i;
  end
endmodule

// File: rtl/i2c_scl_phase_cnt.sv
// Down counter: loaded at a phase start, counts to zero, held at zero on clear.
module i2c_scl_phase_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer
  import i2c_scl_pkg::*;
#(
  parameter int unsigned FIELD_W = FIELD_W_DEF,
  parameter int unsigned HI_MIN  = HI_MIN_DEF,
  parameter int unsigned LO_MIN  = LO_MIN_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [2*FIELD_W-1:0] timing_i,
  output logic                 scl_o,
  output logic                 scl_rise_o,
  output logic                 scl_fall_o,
  output logic                 bit_done_o
);
  localparam int unsigned WORD_W = 2 * FIELD_W;

  logic [FIELD_W-1:0] hi_raw, lo_raw, hi_eff, lo_eff, load_val;
  logic               cnt_zero, cnt_load, cnt_clear;

  scl_phase_e phase_q, phase_d;
  logic scl_q, scl_d, rise_q, rise_d, fall_q, fall_d, done_q, done_d;

  assign hi_raw = timing_i[WORD_W-1:FIELD_W];
  assign lo_raw = timing_i[FIELD_W-1:0];

  i2c_scl_floor #(.W(FIELD_W), .MIN(HI_MIN)) hi_floor_i (
    .raw_i(hi_raw), .eff_o(hi_eff)
  );
  i2c_scl_floor #(.W(FIELD_W), .MIN(LO_MIN)) lo_floor_i (
    .raw_i(lo_raw), .eff_o(lo_eff)
  );

  // A low phase is followed by high; idle and high are followed by low.
  assign load_val = (phase_q == PH_LOW) ? hi_eff : lo_eff;

  i2c_scl_phase_cnt #(.W(FIELD_W)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(cnt_clear),
    .load_i(cnt_load), .load_val_i(load_val), .zero_o(cnt_zero)
  );

  always_comb begin
    phase_d   = phase_q;
    scl_d     = scl_q;
    rise_d    = 1'b0;
    fall_d    = 1'b0;
    done_d    = 1'b0;
    cnt_load  = 1'b0;
    cnt_clear = 1'b0;
    if (!en_i) begin
      phase_d   = PH_IDLE;
      cnt_clear = 1'b1;
      scl_d     = 1'b1;
      rise_d    = !scl_q;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_LOW;
          cnt_load = 1'b1;
          scl_d    = 1'b0;
          fall_d   = 1'b1;
        end
        PH_LOW: begin
          if (cnt_zero) begin
            phase_d  = PH_HIGH;
            cnt_load = 1'b1;
            scl_d    = 1'b1;
            rise_d   = 1'b1;
            done_d   = 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_zero) begin
            phase_d  = PH_LOW;
            cnt_load = 1'b1;
            scl_d    = 1'b0;
            fall_d   = 1'b1;
          end
        end
        default: begin
          phase_d   = PH_IDLE;
          cnt_clear = 1'b1;
          scl_d     = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      scl_q   <= 1'b1;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      scl_q   <= scl_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      done_q  <= done_d;
    end
  end

  assign scl_o      = scl_q;
  assign scl_rise_o = rise_q;
  assign scl_fall_o = fall_q;
  assign bit_done_o = done_q;
endmodule

// File: rtl/i2c_scl_pacer_chk.sv
module i2c_scl_pacer_chk #(
  parameter int unsigned LO_MIN = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic bit_done_o
);
  logic [15:0] lo_run;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || scl_o) lo_run <= '0;
    else                  lo_run <= lo_run + 16'd1;
  end

  assert_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !scl_fall_o && !bit_done_o));

  assert_rise_real_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> (scl_o && !$past(scl_o)));

  assert_fall_real_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |-> (!scl_o && $past(scl_o)));

  assert_edges_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o}));

  assert_done_on_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_done_o |-> scl_rise_o);

  assert_low_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_done_o |-> (lo_run >= 16'(LO_MIN + 1)));

  assert_abort_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !scl_o) |=> (scl_rise_o && !bit_done_o));
endmodule

bind i2c_scl_pacer i2c_scl_pacer_chk #(.LO_MIN(LO_MIN)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .scl_o(scl_o),
  .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o), .bit_done_o(bit_done_o)
);

// File: tb/i2c_scl_pacer_tb_top.sv
module i2c_scl_pacer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] timing_i = 16'h0204;
  logic        scl_o, scl_rise_o, scl_fall_o, bit_done_o;
  int          checks = 0;
  int          fails = 0;

  always #2 clk_i = ~clk_i;

  i2c_scl_pacer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .timing_i(timing_i),
    .scl_o(scl_o), .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o),
    .bit_done_o(bit_done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Disable, load a word, enable; returns at the negedge showing the first fall.
  task automatic start(input logic [15:0] w);
    en_i = 1'b0;
    timing_i = w;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    @(negedge clk_i);
  endtask

  // Called at a fall negedge; measures one low then one high phase.
  task automatic measure(output int lo, output int hi, output int done_seen);
    lo = 0;
    hi = 0;
    while (!scl_o && lo < 1000) begin lo++; @(negedge clk_i); end
    done_seen = (bit_done_o && scl_rise_o) ? 1 : 0;
    while (scl_o && hi < 1000) begin hi++; @(negedge clk_i); end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 scl in reset", scl_o, 1);
    chk("R1 pulses in reset", {scl_rise_o, scl_fall_o, bit_done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 scl after reset", scl_o, 1);
    chk("R1 pulses after reset", {scl_rise_o, scl_fall_o, bit_done_o}, 0);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (!scl_o || scl_fall_o || bit_done_o) bad++;
    end
    chk("R2 idle stays high and quiet", bad, 0);
  endtask

  task automatic t_start();
    start(16'h0A05);
    chk("R3 first cycle scl low", scl_o, 0);
    chk("R3 first cycle fall pulse", scl_fall_o, 1);
  endtask

  task automatic t_lengths(input logic [15:0] w, input int exp_lo, input int exp_hi,
                           input string rl, input string rh);
    int lo, hi, dn;
    start(w);
    measure(lo, hi, dn);
    chk(rl, lo, exp_lo);
    chk(rh, hi, exp_hi);
    chk("R9 strobe at low end", dn, 1);
    chk("R8 fall pulse at next low", scl_fall_o, 1);
    measure(lo, hi, dn);
    chk({rl, " second period"}, lo, exp_lo);
  endtask

  task automatic t_pulse_width();
    int rises = 0, falls = 0, dones = 0;
    start(16'h0305);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      rises += scl_rise_o;
      falls += scl_fall_o;
      dones += bit_done_o;
    end
    // Period 6+4=10 cycles; 40 cycles after the first fall cycle.
    chk("R8 rise pulses in 4 periods", rises, 4);
    chk("R8 fall pulses in 4 periods", falls, 4);
    chk("R9 strobes in 4 periods", dones, 4);
  endtask

  task automatic t_midwrite();
    int lo = 0, hi, lo2, dn;
    start(16'h0A14);
    while (!scl_o && lo < 1000) begin
      lo++;
      if (lo == 5) timing_i = 16'h0005;
      @(negedge clk_i);
    end
    chk("R10 running low phase unchanged", lo, 21);
    hi = 0;
    while (scl_o && hi < 1000) begin hi++; @(negedge clk_i); end
    chk("R10 next high uses new word", hi, 3);
    measure(lo2, hi, dn);
    chk("R10 next low uses new word", lo2, 6);
  endtask

  task automatic t_abort();
    start(16'h0A14);
    repeat (3) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R11 scl high after abort", scl_o, 1);
    chk("R11 rise pulse on abort", scl_rise_o, 1);
    chk("R11 no strobe on abort", bit_done_o, 0);
    @(negedge clk_i);
    chk("R2 pulse ends after abort", scl_rise_o, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_start();
    t_lengths(16'h0A05, 6, 11, "R4 low length", "R5 high length");
    t_lengths(16'h0000, 5, 3, "R6 low clamp zero", "R7 high clamp zero");
    t_lengths(16'h0103, 5, 3, "R6 low clamp 3", "R7 high clamp 1");
    t_lengths(16'h0204, 5, 3, "R6 low floor exact", "R7 high floor exact");
    t_lengths(16'h0706, 7, 8, "R4 low length b", "R5 high length b");
    t_pulse_width();
    t_midwrite();
    t_abort();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule